// File: doc/BRIEF.md
# Two-Thread Data Cache Sharing Controller

This block is the tag-side lookup and fill filter for a small direct-mapped data cache that two hardware threads share. Every line carries a valid bit, a linear tag, a physical tag and the id of the thread that filled it. On each lookup the block decides whether the requesting thread may use the line. The answer depends on a policy bit and on how the two threads' translation contexts compare. Each context is a page-table base value plus a paging-mode code.

The policy bit selects one of two policies. In the adaptive policy, lines are pooled whenever the contexts agree and are private to their filler otherwise. In the shared policy, lines are always private to their filler. The two policies also treat aliases differently: a line whose linear tag matches but whose physical tag does not. The adaptive policy removes such a line at once. The shared policy keeps it resident and leaves the refill to evict it. Data storage, address translation and the memory side are outside the block. The block reports hit, miss, replace and the line index one cycle after the request.

Top module: `ccs_share_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, hit_o, miss_o, repl_o and way_o are 0. Every line starts invalid, so the first lookup to any index reports miss_o=1 and repl_o=0.
- R2: The shared policy is in force only when cap_i=1 and mode_i=1. With cap_i=0 the block behaves as adaptive whatever mode_i is.
- R3: Under the adaptive policy, if t0_base_i equals t1_base_i and t0_pgm_i equals t1_pgm_i, either thread hits on a valid line filled by the other.
- R4: Under the adaptive policy, if the bases differ or the paging modes differ, only the thread that filled a line can hit on it. The other thread misses.
- R5: Under the shared policy, a hit requires the line's owner to equal the requesting thread, even when both contexts are identical.
- R6: A lookup hits when the line at lk_index_i is valid, its linear tag equals lk_lin_i, its physical tag equals lk_phy_i and the access is permitted. The cycle after the request, hit_o=1, miss_o=0 and way_o=lk_index_i.
- R7: A lookup that does not hit gives miss_o=1 the next cycle. repl_o=1 accompanies the miss exactly when the line at that index was valid.
- R8: Under the adaptive policy, a permitted lookup whose linear tag matches and whose physical tag differs misses with repl_o=1 and invalidates the line. A later lookup with the original tags then misses with repl_o=0.
- R9: Under the shared policy, the same alias lookup misses with repl_o=1 but leaves the line valid. A later lookup with the original tags still hits.
- R10: Changes to the base or paging-mode inputs take effect on the very next lookup and flush no lines. Restoring matching contexts restores cross-thread hits on lines already resident.
- R11: When a fill and a lookup hit the same index in the same cycle, the lookup is judged against the line as written by the fill. An alias found that way does not invalidate the newly filled line.
- R12: In a cycle after one with lk_valid_i=0, hit_o, miss_o and repl_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_i | input | 1 | Capability strap; enables the policy bit |
| mode_i | input | 1 | Policy bit: 0 adaptive, 1 shared |
| t0_base_i | input | BASE_W | Page-table base of thread 0 |
| t1_base_i | input | BASE_W | Page-table base of thread 1 |
| t0_pgm_i | input | PGM_W | Paging-mode code of thread 0 |
| t1_pgm_i | input | PGM_W | Paging-mode code of thread 1 |
| lk_valid_i | input | 1 | Lookup request |
| lk_thread_i | input | 1 | Requesting thread id |
| lk_index_i | input | IDX_W | Lookup line index |
| lk_lin_i | input | LIN_W | Lookup linear tag |
| lk_phy_i | input | PHY_W | Lookup physical tag |
| fl_valid_i | input | 1 | Fill request |
| fl_thread_i | input | 1 | Filling thread id (becomes line owner) |
| fl_index_i | input | IDX_W | Fill line index |
| fl_lin_i | input | LIN_W | Fill linear tag |
| fl_phy_i | input | PHY_W | Fill physical tag |
| hit_o | output | 1 | Registered hit |
| miss_o | output | 1 | Registered miss |
| repl_o | output | 1 | Registered replace: the miss evicts a valid line |
| way_o | output | IDX_W | Index of the last lookup |

## Verification
The functions that can collide are a fill and a lookup aimed at the same line index in the same cycle. The bench drives both requests on one clock edge in two cases. In the first the lookup tags equal the fill tags, and the registered result must be a hit, which shows that the lookup sees the new line. In the second the lookup carries a differing physical tag under the adaptive policy. That lookup must report a miss with replace, and a follow-up lookup with the fill's own tags must still hit, which shows that the fill won over the alias invalidation.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  typedef enum logic {
    POL_ADAPTIVE = 1'b0,
    POL_SHARED   = 1'b1
  } policy_e;

  typedef struct packed {
    logic hit;
    logic miss;
    logic repl;
  } lk_resp_t;

endpackage

// File: rtl/ccs_ctx_match.sv
module ccs_ctx_match
  import ccs_pkg::*;
#(
  parameter int BASE_W = 20,
  parameter int PGM_W  = 2
) (
  input  logic              cap_i,
  input  logic              mode_i,
  input  logic [BASE_W-1:0] base0_i,
  input  logic [BASE_W-1:0] base1_i,
  input  logic [PGM_W-1:0]  pgm0_i,
  input  logic [PGM_W-1:0]  pgm1_i,
  output policy_e           policy_o,
  output logic              share_o
);

  // The policy bit counts only when the strap says the feature exists.
  always_comb begin
    policy_o = (cap_i && mode_i) ? POL_SHARED : POL_ADAPTIVE;
    share_o  = (policy_o == POL_ADAPTIVE) &&
               (base0_i == base1_i) &&
               (pgm0_i  == pgm1_i);
  end

endmodule

// File: rtl/ccs_tag_store.sv
module ccs_tag_store #(
  parameter  int NUM_LINES = 16,
  parameter  int LIN_W     = 20,
  parameter  int PHY_W     = 24,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LIN_W-1:0] wr_lin_i,
  input  logic [PHY_W-1:0] wr_phy_i,
  input  logic             wr_own_i,
  input  logic             inv_en_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [LIN_W-1:0] rd_lin_o,
  output logic [PHY_W-1:0] rd_phy_o,
  output logic             rd_own_o
);

  logic [NUM_LINES-1:0] valid_vec;
  logic [NUM_LINES-1:0] own_vec;
  logic [LIN_W-1:0]     lin_arr [NUM_LINES];
  logic [PHY_W-1:0]     phy_arr [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic             v_q, v_d;
    logic             tag_en;
    logic [LIN_W-1:0] lin_q;
    logic [PHY_W-1:0] phy_q;
    logic             own_q;

    // Fill has priority over invalidation on the same line.
    always_comb begin
      tag_en = wr_en_i && (wr_idx_i == IDX_W'(g));
      v_d    = v_q;
      if (tag_en) begin
        v_d = 1'b1;
      end else if (inv_en_i && (inv_idx_i == IDX_W'(g))) begin
        v_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else begin
        v_q <= v_d;
      end
    end

    // Tag fields need no reset: the valid bit qualifies them.
    always_ff @(posedge clk) begin
      if (tag_en) begin
        lin_q <= wr_lin_i;
        phy_q <= wr_phy_i;
        own_q <= wr_own_i;
      end
    end

    assign valid_vec[g] = v_q;
    assign own_vec[g]   = own_q;
    assign lin_arr[g]   = lin_q;
    assign phy_arr[g]   = phy_q;
  end

  assign rd_valid_o = valid_vec[rd_idx_i];
  assign rd_own_o   = own_vec[rd_idx_i];
  assign rd_lin_o   = lin_arr[rd_idx_i];
  assign rd_phy_o   = phy_arr[rd_idx_i];

endmodule

// File: rtl/ccs_lookup_eval.sv
module ccs_lookup_eval #(
  parameter int LIN_W = 20,
  parameter int PHY_W = 24
) (
  input  logic             share_i,
  input  logic             req_thread_i,
  input  logic [LIN_W-1:0] req_lin_i,
  input  logic [PHY_W-1:0] req_phy_i,
  input  logic             line_valid_i,
  input  logic [LIN_W-1:0] line_lin_i,
  input  logic [PHY_W-1:0] line_phy_i,
  input  logic             line_own_i,
  output logic             hit_o,
  output logic             alias_o
);

  logic permit;
  logic lin_eq;

  always_comb begin
    permit  = share_i || (line_own_i == req_thread_i);
    lin_eq  = line_valid_i && (line_lin_i == req_lin_i);
    hit_o   = lin_eq && permit && (line_phy_i == req_phy_i);
    alias_o = lin_eq && permit && (line_phy_i != req_phy_i);
  end

endmodule

// File: rtl/ccs_share_ctrl.sv
module ccs_share_ctrl
  import ccs_pkg::*;
#(
  parameter  int NUM_LINES = 16,
  parameter  int LIN_W     = 20,
  parameter  int PHY_W     = 24,
  parameter  int BASE_W    = 20,
  parameter  int PGM_W     = 2,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              mode_i,
  input  logic [BASE_W-1:0] t0_base_i,
  input  logic [BASE_W-1:0] t1_base_i,
  input  logic [PGM_W-1:0]  t0_pgm_i,
  input  logic [PGM_W-1:0]  t1_pgm_i,
  input  logic              lk_valid_i,
  input  logic              lk_thread_i,
  input  logic [IDX_W-1:0]  lk_index_i,
  input  logic [LIN_W-1:0]  lk_lin_i,
  input  logic [PHY_W-1:0]  lk_phy_i,
  input  logic              fl_valid_i,
  input  logic              fl_thread_i,
  input  logic [IDX_W-1:0]  fl_index_i,
  input  logic [LIN_W-1:0]  fl_lin_i,
  input  logic [PHY_W-1:0]  fl_phy_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              repl_o,
  output logic [IDX_W-1:0]  way_o
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rsync_q[1];

  // Context comparison
  policy_e policy;
  logic    share_ok;

  ccs_ctx_match #(
    .BASE_W (BASE_W),
    .PGM_W  (PGM_W)
  ) u_ctx (
    .cap_i    (cap_i),
    .mode_i   (mode_i),
    .base0_i  (t0_base_i),
    .base1_i  (t1_base_i),
    .pgm0_i   (t0_pgm_i),
    .pgm1_i   (t1_pgm_i),
    .policy_o (policy),
    .share_o  (share_ok)
  );

  // Tag storage
  logic             st_valid;
  logic [LIN_W-1:0] st_lin;
  logic [PHY_W-1:0] st_phy;
  logic             st_own;
  logic             inv_en;

  ccs_tag_store #(
    .NUM_LINES (NUM_LINES),
    .LIN_W     (LIN_W),
    .PHY_W     (PHY_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en_i    (fl_valid_i),
    .wr_idx_i   (fl_index_i),
    .wr_lin_i   (fl_lin_i),
    .wr_phy_i   (fl_phy_i),
    .wr_own_i   (fl_thread_i),
    .inv_en_i   (inv_en),
    .inv_idx_i  (lk_index_i),
    .rd_idx_i   (lk_index_i),
    .rd_valid_o (st_valid),
    .rd_lin_o   (st_lin),
    .rd_phy_o   (st_phy),
    .rd_own_o   (st_own)
  );

  // Fill-to-lookup bypass on a shared index
  logic             same_idx;
  logic             view_valid;
  logic [LIN_W-1:0] view_lin;
  logic [PHY_W-1:0] view_phy;
  logic             view_own;

  always_comb begin
    same_idx   = fl_valid_i && (fl_index_i == lk_index_i);
    view_valid = same_idx ? 1'b1        : st_valid;
    view_lin   = same_idx ? fl_lin_i    : st_lin;
    view_phy   = same_idx ? fl_phy_i    : st_phy;
    view_own   = same_idx ? fl_thread_i : st_own;
  end

  logic hit_c;
  logic alias_c;

  ccs_lookup_eval #(
    .LIN_W (LIN_W),
    .PHY_W (PHY_W)
  ) u_eval (
    .share_i      (share_ok),
    .req_thread_i (lk_thread_i),
    .req_lin_i    (lk_lin_i),
    .req_phy_i    (lk_phy_i),
    .line_valid_i (view_valid),
    .line_lin_i   (view_lin),
    .line_phy_i   (view_phy),
    .line_own_i   (view_own),
    .hit_o        (hit_c),
    .alias_o      (alias_c)
  );

  // Next-state
  lk_resp_t         resp_d, resp_q;
  logic [IDX_W-1:0] way_d, way_q;
  logic             way_en;

  always_comb begin
    resp_d.hit  = lk_valid_i && hit_c;
    resp_d.miss = lk_valid_i && !hit_c;
    resp_d.repl = lk_valid_i && !hit_c && view_valid;
    inv_en      = lk_valid_i && alias_c && (policy == POL_ADAPTIVE) && !same_idx;
    way_en      = lk_valid_i;
    way_d       = lk_index_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      resp_q <= '0;
      way_q  <= '0;
    end else begin
      resp_q <= resp_d;
      if (way_en) begin
        way_q <= way_d;
      end
    end
  end

  assign hit_o  = resp_q.hit;
  assign miss_o = resp_q.miss;
  assign repl_o = resp_q.repl;
  assign way_o  = way_q;

endmodule

// File: rtl/ccs_share_ctrl_chk.sv
module ccs_share_ctrl_chk #(
  parameter  int NUM_LINES = 16,
  parameter  int LIN_W     = 20,
  parameter  int PHY_W     = 24,
  parameter  int BASE_W    = 20,
  parameter  int PGM_W     = 2,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_i,
  input logic              mode_i,
  input logic [BASE_W-1:0] t0_base_i,
  input logic [BASE_W-1:0] t1_base_i,
  input logic [PGM_W-1:0]  t0_pgm_i,
  input logic [PGM_W-1:0]  t1_pgm_i,
  input logic              lk_valid_i,
  input logic              lk_thread_i,
  input logic [IDX_W-1:0]  lk_index_i,
  input logic [LIN_W-1:0]  lk_lin_i,
  input logic [PHY_W-1:0]  lk_phy_i,
  input logic              fl_valid_i,
  input logic              fl_thread_i,
  input logic [IDX_W-1:0]  fl_index_i,
  input logic [LIN_W-1:0]  fl_lin_i,
  input logic [PHY_W-1:0]  fl_phy_i,
  input logic              hit_o,
  input logic              miss_o,
  input logic              repl_o,
  input logic [IDX_W-1:0]  way_o
);

  logic same_line_fill;
  assign same_line_fill = lk_valid_i && fl_valid_i && (fl_index_i == lk_index_i) &&
                          (fl_lin_i == lk_lin_i) && (fl_phy_i == lk_phy_i);

  a_r6_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && miss_o));

  a_r7_repl_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    repl_o |-> miss_o);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |=> !(hit_o || miss_o || repl_o));

  a_r6_way_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |=> (way_o == $past(lk_index_i)) && (hit_o || miss_o));

  a_r11_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (same_line_fill && (fl_thread_i == lk_thread_i)) |=> hit_o);

  a_r5_shared_private: assert property (@(posedge clk) disable iff (!rst_n)
    (same_line_fill && cap_i && mode_i && (fl_thread_i != lk_thread_i)) |=> !hit_o);

  a_r2_strap_off: assert property (@(posedge clk) disable iff (!rst_n)
    (same_line_fill && !cap_i && (fl_thread_i != lk_thread_i) &&
     (t0_base_i == t1_base_i) && (t0_pgm_i == t1_pgm_i)) |=> hit_o);

endmodule

bind ccs_share_ctrl ccs_share_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .LIN_W     (LIN_W),
  .PHY_W     (PHY_W),
  .BASE_W    (BASE_W),
  .PGM_W     (PGM_W)
) u_chk (
  .rst_n (rst_sync_n),
  .*
);

// File: tb/ccs_share_ctrl_bench.sv
`timescale 1ns/1ps
module ccs_share_ctrl_bench;

  localparam int NUM_LINES = 16;
  localparam int LIN_W     = 20;
  localparam int PHY_W     = 24;
  localparam int BASE_W    = 20;
  localparam int PGM_W     = 2;
  localparam int IDX_W     = $clog2(NUM_LINES);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cap_i, mode_i;
  logic [BASE_W-1:0] t0_base_i, t1_base_i;
  logic [PGM_W-1:0]  t0_pgm_i, t1_pgm_i;
  logic              lk_valid_i, lk_thread_i;
  logic [IDX_W-1:0]  lk_index_i;
  logic [LIN_W-1:0]  lk_lin_i;
  logic [PHY_W-1:0]  lk_phy_i;
  logic              fl_valid_i, fl_thread_i;
  logic [IDX_W-1:0]  fl_index_i;
  logic [LIN_W-1:0]  fl_lin_i;
  logic [PHY_W-1:0]  fl_phy_i;
  logic              hit_o, miss_o, repl_o;
  logic [IDX_W-1:0]  way_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ccs_share_ctrl #(
    .NUM_LINES (NUM_LINES), .LIN_W (LIN_W), .PHY_W (PHY_W),
    .BASE_W (BASE_W), .PGM_W (PGM_W)
  ) u_ccs_share_ctrl (
    .clk (clk), .rst_n (rst_n), .cap_i (cap_i), .mode_i (mode_i),
    .t0_base_i (t0_base_i), .t1_base_i (t1_base_i),
    .t0_pgm_i (t0_pgm_i), .t1_pgm_i (t1_pgm_i),
    .lk_valid_i (lk_valid_i), .lk_thread_i (lk_thread_i),
    .lk_index_i (lk_index_i), .lk_lin_i (lk_lin_i), .lk_phy_i (lk_phy_i),
    .fl_valid_i (fl_valid_i), .fl_thread_i (fl_thread_i),
    .fl_index_i (fl_index_i), .fl_lin_i (fl_lin_i), .fl_phy_i (fl_phy_i),
    .hit_o (hit_o), .miss_o (miss_o), .repl_o (repl_o), .way_o (way_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_lk(input logic th, input int idx, input int lin, input int phy);
    lk_valid_i  = 1'b1;
    lk_thread_i = th;
    lk_index_i  = IDX_W'(idx);
    lk_lin_i    = LIN_W'(lin);
    lk_phy_i    = PHY_W'(phy);
  endtask

  task automatic drive_fl(input logic th, input int idx, input int lin, input int phy);
    fl_valid_i  = 1'b1;
    fl_thread_i = th;
    fl_index_i  = IDX_W'(idx);
    fl_lin_i    = LIN_W'(lin);
    fl_phy_i    = PHY_W'(phy);
  endtask

  task automatic expect_resp(input string req, input logic eh, input logic em,
                             input logic er, input int idx);
    check(req, {25'd0, hit_o, miss_o, repl_o, way_o},
               {25'd0, eh, em, er, IDX_W'(idx)});
  endtask

  task automatic fill(input logic th, input int idx, input int lin, input int phy);
    @(negedge clk);
    drive_fl(th, idx, lin, phy);
    @(negedge clk);
    fl_valid_i = 1'b0;
  endtask

  task automatic lookup(input string req, input logic th, input int idx, input int lin,
                        input int phy, input logic eh, input logic em, input logic er);
    @(negedge clk);
    drive_lk(th, idx, lin, phy);
    @(negedge clk);
    lk_valid_i = 1'b0;
    expect_resp(req, eh, em, er, idx);
  endtask

  task automatic set_ctx(input int b0, input int b1, input int p0, input int p1);
    @(negedge clk);
    t0_base_i = BASE_W'(b0);
    t1_base_i = BASE_W'(b1);
    t0_pgm_i  = PGM_W'(p0);
    t1_pgm_i  = PGM_W'(p1);
  endtask

  task automatic set_policy(input logic cap, input logic mode);
    @(negedge clk);
    cap_i  = cap;
    mode_i = mode;
  endtask

  // R1: reset state and first lookups
  task automatic t_reset;
    check("R1 outputs in reset", {28'd0, hit_o, miss_o, repl_o}, 32'd0);
    check("R1 way in reset", {28'd0, way_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after release", {28'd0, hit_o, miss_o, repl_o}, 32'd0);
    repeat (3) @(negedge clk);
    lookup("R1 empty line", 1'b0, 3, 'h111, 'h222, 1'b0, 1'b1, 1'b0);
    lookup("R1 empty line high index", 1'b1, 15, 'h0, 'h0, 1'b0, 1'b1, 1'b0);
  endtask

  // R3 R6 R7 R12: adaptive pooling with matching contexts
  task automatic t_adaptive_share;
    set_policy(1'b1, 1'b0);
    set_ctx('h5000, 'h5000, 1, 1);
    fill(1'b0, 2, 'hAAAA, 'h0C0C0);
    lookup("R6 owner hit", 1'b0, 2, 'hAAAA, 'h0C0C0, 1'b1, 1'b0, 1'b0);
    lookup("R3 cross-thread hit", 1'b1, 2, 'hAAAA, 'h0C0C0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R12 idle after lookup", {29'd0, hit_o, miss_o, repl_o}, 32'd0);
    lookup("R7 tag mismatch replaces", 1'b0, 2, 'hBBBB, 'h0C0C0, 1'b0, 1'b1, 1'b1);
  endtask

  // R4 R10: competing lines and context changes without flush
  task automatic t_compete;
    set_ctx('h5000, 'h6000, 1, 1);
    lookup("R4 base differs other thread", 1'b1, 2, 'hAAAA, 'h0C0C0, 1'b0, 1'b1, 1'b1);
    lookup("R4 base differs owner", 1'b0, 2, 'hAAAA, 'h0C0C0, 1'b1, 1'b0, 1'b0);
    set_ctx('h5000, 'h5000, 1, 1);
    lookup("R10 restored context hit", 1'b1, 2, 'hAAAA, 'h0C0C0, 1'b1, 1'b0, 1'b0);
    set_ctx('h5000, 'h5000, 1, 2);
    lookup("R4 paging mode differs", 1'b1, 2, 'hAAAA, 'h0C0C0, 1'b0, 1'b1, 1'b1);
    set_ctx('h5000, 'h5000, 1, 1);
  endtask

  // R2 R5: strap gating and shared policy ownership
  task automatic t_policy;
    set_policy(1'b0, 1'b1);
    lookup("R2 strap off acts adaptive", 1'b1, 2, 'hAAAA, 'h0C0C0, 1'b1, 1'b0, 1'b0);
    set_policy(1'b1, 1'b1);
    lookup("R5 shared other thread", 1'b1, 2, 'hAAAA, 'h0C0C0, 1'b0, 1'b1, 1'b1);
    lookup("R5 shared owner", 1'b0, 2, 'hAAAA, 'h0C0C0, 1'b1, 1'b0, 1'b0);
    set_policy(1'b1, 1'b0);
  endtask

  // R9: alias kept resident under shared policy
  task automatic t_shared_alias;
    set_policy(1'b1, 1'b1);
    fill(1'b0, 5, 'h1234, 'h00A1);
    lookup("R9 alias miss", 1'b0, 5, 'h1234, 'h00A2, 1'b0, 1'b1, 1'b1);
    lookup("R9 line retained", 1'b0, 5, 'h1234, 'h00A1, 1'b1, 1'b0, 1'b0);
    set_policy(1'b1, 1'b0);
  endtask

  // R8: alias removed under adaptive policy
  task automatic t_adaptive_alias;
    fill(1'b1, 6, 'h4321, 'h00B1);
    lookup("R8 alias miss", 1'b1, 6, 'h4321, 'h00B2, 1'b0, 1'b1, 1'b1);
    lookup("R8 line invalidated", 1'b1, 6, 'h4321, 'h00B1, 1'b0, 1'b1, 1'b0);
  endtask

  // R11: fill and lookup on one index in one cycle
  task automatic t_collide;
    fill(1'b0, 7, 'h0707, 'h7770);
    @(negedge clk);
    drive_fl(1'b1, 7, 'h0808, 'h8880);
    drive_lk(1'b1, 7, 'h0808, 'h8880);
    @(negedge clk);
    fl_valid_i = 1'b0; lk_valid_i = 1'b0;
    expect_resp("R11 lookup sees fill", 1'b1, 1'b0, 1'b0, 7);
    @(negedge clk);
    drive_fl(1'b0, 8, 'h0909, 'h9990);
    drive_lk(1'b0, 8, 'h0909, 'h9991);
    @(negedge clk);
    fl_valid_i = 1'b0; lk_valid_i = 1'b0;
    expect_resp("R11 alias against fill", 1'b0, 1'b1, 1'b1, 8);
    lookup("R11 fill survives alias", 1'b0, 8, 'h0909, 'h9990, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    cap_i = 1'b0; mode_i = 1'b0;
    t0_base_i = '0; t1_base_i = '0; t0_pgm_i = '0; t1_pgm_i = '0;
    lk_valid_i = 1'b0; lk_thread_i = 1'b0; lk_index_i = '0; lk_lin_i = '0; lk_phy_i = '0;
    fl_valid_i = 1'b0; fl_thread_i = 1'b0; fl_index_i = '0; fl_lin_i = '0; fl_phy_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_adaptive_share();
    t_compete();
    t_policy();
    t_shared_alias();
    t_adaptive_alias();
    t_collide();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule